// File: doc/BRIEF.md
# USB Endpoint Data Toggle Checker

This block sits behind the receive side of a USB device controller and decides what happens to each OUT or SETUP data packet once the packet has ended. It keeps one sequence bit per endpoint, which holds the PID it expects next (0 = DATA0, 1 = DATA1). It compares that bit with the PID of the packet that just finished. A packet whose PID matches is passed upstream. A packet whose PID does not match is taken as a repeat of data already received: it is dropped without notice to the device software, but it is still answered with a positive handshake so that the host stops resending it.

The handshake is ACK or NYET. NYET is chosen when the endpoint can use NYET (a high-speed bulk or control OUT endpoint) and the endpoint reports that it has no room for another packet. A packet with a bad CRC gets no handshake and leaves every sequence bit alone. A test-only inhibit input turns the comparison off, so that every packet with a good CRC is delivered. Per-endpoint clear inputs force the sequence bit back to DATA0. On a control endpoint, a SETUP packet is always taken and sets the expected PID of the following data stage to DATA1.

Top module: `usb_toggle_chk`

## Requirements
- R1: While reset is asserted, and after it is released, every bit of `toggle_state` is 0 and `res_valid` is 0 until a packet ends.
- R2: A packet with a good CRC whose PID bit (`pkt_data1`, 1 = DATA1) equals the endpoint's `toggle_state` bit is delivered (`res_deliver` = 1), and that endpoint's bit inverts.
- R3: A packet with a good CRC whose PID bit differs from the endpoint's bit is dropped (`res_deliver` = 0) and the bit does not change. Its `res_hs` is still ACK or NYET and never none.
- R4: `res_hs` is 2'b10 (NYET) for a good-CRC non-SETUP packet when both `ep_nyet_cap[ep]` and `ep_full[ep]` are 1, and 2'b01 (ACK) for every other good-CRC packet, SETUP packets included.
- R5: A packet with a bad CRC gives `res_hs` = 2'b00 (none) and `res_deliver` = 0, and it changes no `toggle_state` bit.
- R6: While `toggle_inhibit` is 1, every good-CRC packet is delivered whatever its PID, and the endpoint's bit still inverts.
- R7: `ep_clear[i]` = 1 sets bit i of `toggle_state` to 0 at the next clock edge. It takes priority over a packet for the same endpoint in the same cycle.
- R8: A good-CRC packet with `pkt_setup` = 1 on an endpoint whose `CTRL_MASK` bit is 1 is delivered whatever its PID, and it sets that endpoint's bit to 1. On an endpoint that is not a control endpoint, `pkt_setup` has no effect and the packet is handled as ordinary data.
- R9: A packet changes only the `toggle_state` bit of its own endpoint (`pkt_ep`).
- R10: `res_valid`, `res_deliver`, `res_hs` and the new `toggle_state` appear one clock after the cycle in which `pkt_done` is 1. In every other cycle `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pkt_done | input | 1 | One-cycle strobe: a data packet has ended |
| pkt_ep | input | EP_W | Endpoint number of the packet |
| pkt_data1 | input | 1 | PID of the packet: 0 = DATA0, 1 = DATA1 |
| pkt_crc_ok | input | 1 | The packet's CRC was good |
| pkt_setup | input | 1 | The packet is the data of a SETUP transaction |
| toggle_inhibit | input | 1 | Test mode: accept every packet whatever its PID |
| ep_clear | input | NUM_EP | Per-endpoint force to DATA0 |
| ep_nyet_cap | input | NUM_EP | Endpoint may answer with NYET |
| ep_full | input | NUM_EP | Endpoint has no room for another packet |
| res_valid | output | 1 | A decision is present this cycle |
| res_deliver | output | 1 | 1 = pass the packet upstream, 0 = drop it |
| res_hs | output | 2 | Handshake: 00 none, 01 ACK, 10 NYET |
| toggle_state | output | NUM_EP | Expected next PID of each endpoint |

## Verification
Each decision (`res_valid`, `res_deliver`, `res_hs`) and the updated `toggle_state` is due exactly one rising edge after the cycle that carries `pkt_done`. `ep_clear` also acts at the next edge. The bench drives every stimulus on a falling edge and samples on the following falling edge, so each value is read half a period after the register that produces it has loaded. It checks in the cycle after that as well, to confirm that `res_valid` has returned to 0.

// File: rtl/toggle_pkg.sv
package toggle_pkg;

  typedef enum logic [1:0] {
    HS_NONE = 2'b00,
    HS_ACK  = 2'b01,
    HS_NYET = 2'b10
  } hs_e;

  typedef struct packed {
    logic accept;
    logic setup_hit;
    logic next_tog;
  } verdict_t;

endpackage

// File: rtl/tc_reset_sync.sv
module tc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/tc_decide.sv
module tc_decide
  import toggle_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter logic [NUM_EP-1:0] CTRL_MASK = 'b1,
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic [EP_W-1:0]   ep,
  input  logic              data1,
  input  logic              crc_ok,
  input  logic              is_setup,
  input  logic              inhibit,
  input  logic [NUM_EP-1:0] tog_vec,
  output verdict_t          verdict
);

  logic cur_tog;
  logic is_ctrl;
  logic pid_match;

  always_comb begin
    cur_tog   = tog_vec[ep];
    is_ctrl   = CTRL_MASK[ep];
    pid_match = (data1 == cur_tog);

    verdict.setup_hit = is_setup & is_ctrl;
    verdict.accept    = crc_ok & (verdict.setup_hit | inhibit | pid_match);

    if (verdict.setup_hit)   verdict.next_tog = 1'b1;
    else if (verdict.accept) verdict.next_tog = ~cur_tog;
    else                     verdict.next_tog = cur_tog;
  end

endmodule

// File: rtl/tc_hs_select.sv
module tc_hs_select
  import toggle_pkg::*;
(
  input  logic crc_ok,
  input  logic setup_hit,
  input  logic nyet_cap,
  input  logic full,
  output hs_e  hs
);

  always_comb begin
    if (!crc_ok)                           hs = HS_NONE;
    else if (!setup_hit && nyet_cap && full) hs = HS_NYET;
    else                                   hs = HS_ACK;
  end

endmodule

// File: rtl/tc_toggle_bank.sv
module tc_toggle_bank #(
  parameter int NUM_EP = 4,
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [EP_W-1:0]   wr_ep,
  input  logic              wr_val,
  input  logic [NUM_EP-1:0] clear,
  output logic [NUM_EP-1:0] tog_q
);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic en;
    logic d;

    always_comb begin
      en = clear[i] | (wr_en & (wr_ep == EP_W'(i)));
      d  = clear[i] ? 1'b0 : wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tog_q[i] <= 1'b0;
      else if (en) tog_q[i] <= d;
    end
  end

endmodule

// File: rtl/usb_toggle_chk.sv
module usb_toggle_chk
  import toggle_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter logic [NUM_EP-1:0] CTRL_MASK = 'b1,
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_done,
  input  logic [EP_W-1:0]   pkt_ep,
  input  logic              pkt_data1,
  input  logic              pkt_crc_ok,
  input  logic              pkt_setup,
  input  logic              toggle_inhibit,
  input  logic [NUM_EP-1:0] ep_clear,
  input  logic [NUM_EP-1:0] ep_nyet_cap,
  input  logic [NUM_EP-1:0] ep_full,
  output logic              res_valid,
  output logic              res_deliver,
  output logic [1:0]        res_hs,
  output logic [NUM_EP-1:0] toggle_state
);

  logic     rst_sync_n;
  verdict_t verdict;
  hs_e      hs_sel;

  logic     valid_q,   valid_d;
  logic     deliver_q, deliver_d;
  hs_e      hs_q,      hs_d;

  tc_reset_sync #(.STAGES(2)) u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tc_decide #(.NUM_EP(NUM_EP), .CTRL_MASK(CTRL_MASK)) u_decide (
    .ep       (pkt_ep),
    .data1    (pkt_data1),
    .crc_ok   (pkt_crc_ok),
    .is_setup (pkt_setup),
    .inhibit  (toggle_inhibit),
    .tog_vec  (toggle_state),
    .verdict  (verdict)
  );

  tc_hs_select u_hs (
    .crc_ok    (pkt_crc_ok),
    .setup_hit (verdict.setup_hit),
    .nyet_cap  (ep_nyet_cap[pkt_ep]),
    .full      (ep_full[pkt_ep]),
    .hs        (hs_sel)
  );

  tc_toggle_bank #(.NUM_EP(NUM_EP)) u_bank (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (pkt_done & pkt_crc_ok),
    .wr_ep  (pkt_ep),
    .wr_val (verdict.next_tog),
    .clear  (ep_clear),
    .tog_q  (toggle_state)
  );

  always_comb begin
    valid_d   = pkt_done;
    deliver_d = pkt_done & verdict.accept;
    hs_d      = pkt_done ? hs_sel : HS_NONE;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q   <= 1'b0;
      deliver_q <= 1'b0;
      hs_q      <= HS_NONE;
    end else begin
      valid_q   <= valid_d;
      deliver_q <= deliver_d;
      hs_q      <= hs_d;
    end
  end

  assign res_valid   = valid_q;
  assign res_deliver = deliver_q;
  assign res_hs      = hs_q;

endmodule

// File: rtl/usb_toggle_chk_sva.sv
module usb_toggle_chk_sva #(
  parameter int NUM_EP = 4,
  parameter logic [NUM_EP-1:0] CTRL_MASK = 'b1,
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pkt_done,
  input logic [EP_W-1:0]   pkt_ep,
  input logic              pkt_data1,
  input logic              pkt_crc_ok,
  input logic              pkt_setup,
  input logic              toggle_inhibit,
  input logic [NUM_EP-1:0] ep_clear,
  input logic [NUM_EP-1:0] ep_nyet_cap,
  input logic [NUM_EP-1:0] ep_full,
  input logic              res_valid,
  input logic              res_deliver,
  input logic [1:0]        res_hs,
  input logic [NUM_EP-1:0] toggle_state
);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_done |=> !res_valid);

  assert_done_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> res_valid);

  assert_good_crc_hs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done && pkt_crc_ok |=> (res_hs == 2'b01 || res_hs == 2'b10));

  assert_bad_crc_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done && !pkt_crc_ok |=> (res_hs == 2'b00 && !res_deliver));

  assert_bad_crc_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done && !pkt_crc_ok && ep_clear == '0 |=> $stable(toggle_state));

  assert_inhibit_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done && pkt_crc_ok && toggle_inhibit |=> res_deliver);

  assert_mismatch_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done && pkt_crc_ok && !toggle_inhibit && !(pkt_setup && CTRL_MASK[pkt_ep])
    && (pkt_data1 != toggle_state[pkt_ep]) && ep_clear == '0
    |=> !res_deliver && $stable(toggle_state));

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ep_clear != '0 |=> ((toggle_state & $past(ep_clear)) == '0));

  assert_one_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done && ep_clear == '0 |=> $countones(toggle_state ^ $past(toggle_state)) <= 1);

endmodule

bind usb_toggle_chk usb_toggle_chk_sva #(.NUM_EP(NUM_EP), .CTRL_MASK(CTRL_MASK)) u_sva (.*);

// File: tb/usb_toggle_chk_test.sv
module usb_toggle_chk_test;

  localparam int NUM_EP = 4;
  localparam int EP_W   = 2;
  localparam logic [NUM_EP-1:0] CTRL_MASK = 4'b0001;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pkt_done = 1'b0;
  logic [EP_W-1:0]   pkt_ep = '0;
  logic              pkt_data1 = 1'b0;
  logic              pkt_crc_ok = 1'b0;
  logic              pkt_setup = 1'b0;
  logic              toggle_inhibit = 1'b0;
  logic [NUM_EP-1:0] ep_clear = '0;
  logic [NUM_EP-1:0] ep_nyet_cap = 4'b0110;
  logic [NUM_EP-1:0] ep_full = '0;
  logic              res_valid;
  logic              res_deliver;
  logic [1:0]        res_hs;
  logic [NUM_EP-1:0] toggle_state;

  int errors = 0;
  int checks = 0;
  logic [NUM_EP-1:0] model = '0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  usb_toggle_chk #(.NUM_EP(NUM_EP), .CTRL_MASK(CTRL_MASK)) uut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drives one packet on a falling edge, samples on the next falling edge.
  task automatic send(input int ep, input bit pid, input bit crc, input bit su,
                      input bit inh, input logic [NUM_EP-1:0] clr);
    bit tog, ctl, take;
    int hs_exp;
    string tag;
    tog  = model[ep];
    ctl  = CTRL_MASK[ep] & su;
    take = crc & (ctl | inh | (pid == tog));
    if (!crc)                              hs_exp = 0;
    else if (!ctl && ep_nyet_cap[ep] && ep_full[ep]) hs_exp = 2;
    else                                   hs_exp = 1;
    if (crc) model[ep] = ctl ? 1'b1 : (take ? ~tog : tog);
    model = model & ~clr;
    if (!crc)           tag = "R5 deliver";
    else if (ctl)       tag = "R8 deliver";
    else if (inh)       tag = "R6 deliver";
    else if (pid == tog) tag = "R2 deliver";
    else                tag = "R3 deliver";
    pkt_done = 1'b1; pkt_ep = EP_W'(ep); pkt_data1 = pid; pkt_crc_ok = crc;
    pkt_setup = su; toggle_inhibit = inh; ep_clear = clr;
    @(negedge clk);
    pkt_done = 1'b0; ep_clear = '0;
    check("R10 valid", int'(res_valid), 1);
    check(tag, int'(res_deliver), int'(take));
    check(crc ? "R4 handshake" : "R5 handshake", int'(res_hs), hs_exp);
    check(clr != 0 ? "R7 toggle" : "R9 toggle", int'(toggle_state), int'(model));
    @(negedge clk);
    check("R10 idle", int'(res_valid), 0);
  endtask

  initial begin
    int iter;
    repeat (3) @(negedge clk);
    check("R1 reset toggle", int'(toggle_state), 0);
    check("R1 reset valid", int'(res_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset toggle", int'(toggle_state), 0);
    check("R1 after reset valid", int'(res_valid), 0);

    iter = 0;
    for (int ep = 0; ep < NUM_EP; ep++)
      for (int inh = 0; inh < 2; inh++)
        for (int crc = 0; crc < 2; crc++)
          for (int su = 0; su < 2; su++)
            for (int pid = 0; pid < 2; pid++) begin
              ep_full = NUM_EP'(iter ^ (iter >> 2));
              send(ep, pid[0], crc[0], su[0], inh[0], '0);
              iter++;
            end

    // mismatch repeated on each endpoint: state must not move
    for (int ep = 0; ep < NUM_EP; ep++) begin
      send(ep, ~model[ep], 1'b1, 1'b0, 1'b0, '0);
      send(ep, ~model[ep], 1'b1, 1'b0, 1'b0, '0);
      send(ep, model[ep], 1'b1, 1'b0, 1'b0, '0);
    end

    // clear collides with a packet on the same endpoint; clear wins
    for (int ep = 0; ep < NUM_EP; ep++) begin
      if (model[ep] == 1'b0) send(ep, 1'b0, 1'b1, 1'b0, 1'b0, '0);
      send(ep, model[ep], 1'b1, 1'b0, 1'b0, NUM_EP'(1 << ep));
      check("R7 cleared bit", int'(toggle_state[ep]), 0);
    end

    // clear alone on all endpoints after setting them
    send(0, 1'b1, 1'b1, 1'b1, 1'b0, '0);
    ep_clear = 4'b1111;
    model = '0;
    @(negedge clk);
    ep_clear = '0;
    check("R7 clear all", int'(toggle_state), 0);
    check("R10 clear no valid", int'(res_valid), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule